// File: doc/BRIEF.md
# Iterative CORDIC Square Root

This unit returns the square root of one fixed-point sample at a time. The input and the result share one format: 16 bits, two's complement, with 10 fraction bits. Only shifts, adds and compares are used. One hyperbolic CORDIC stage in vectoring mode is reused on every iteration. The unit suits designs where area matters more than throughput: one computation is in flight at a time, and both sides use a ready/valid handshake.

An accepted sample first goes through normalization. The sample is shifted left by an even number of places until it lies in [0.5, 2). That range is reached by a log-step leading-zero search over several cycles. Next the kernel is loaded with x = m + c and y = m − c, where c = 0.25 / K² and K is the hyperbolic gain of the shift sequence. Because x² − y² = m / K², the final x already equals √m, so no gain-correction multiply is needed. The shift sequence runs from 1 to 15, and shifts 4 and 13 are each used twice, giving 17 iterations. The result is then shifted right by half the normalization shift, rounded to nearest, registered, and held until the consumer takes it.

A Moore controller drives the handshake, the phase counter and the shift sequence. It is kept separate from the normalization, kernel and scaling datapath.

Top module: `cordic_sqrt_iter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. From the next cycle, in_ready is 0.
- R3: While a computation is in progress or a result is waiting, in_valid and in_data have no effect. The delivered result belongs to the accepted sample.
- R4: out_valid rises on the 23rd rising edge after the accepting edge. The accept transfer and the output transfer are therefore 24 cycles apart when the consumer is ready (5 normalization cycles, 17 iterations, 2 output cycles).
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R6: After a rising edge with out_valid and out_ready both 1, out_valid is 0 and in_ready is 1 in the very next cycle.
- R7: in_ready and out_valid are never 1 in the same cycle.
- R8: For an input with bit 15 equal to 0 and a nonzero value u, out_data is within 1 LSB of √(u/1024)·1024. Output format is 16-bit with 10 fraction bits.
- R9: An input of 0 gives out_data exactly 0.
- R10: An input with bit 15 set (negative) gives out_data exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a sample |
| in_ready | output | 1 | Unit is idle and takes a sample |
| in_data | input | 16 | Sample, signed, 10 fraction bits |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Square root, signed, 10 fraction bits |

## Verification
Directed samples cover zero, the smallest codes 1 to 4, exact squares such as 1.0 and 4.0, the largest positive code and negative codes. Odd and even leading-one positions test both normalization parities, and the extremes test the widest and narrowest rescaling shifts. Seeded random magnitudes check accuracy across the whole range. During every computation, junk is driven on the input side to show it is ignored. Random consumer stalls separate holding the result from dropping it, and from reopening the input one cycle late.

// File: rtl/cordic_sqrt_pkg.sv
package cordic_sqrt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_ITER,
    ST_SCALE,
    ST_WRITE,
    ST_HOLD
  } sqrt_state_e;

  // Iteration count of the hyperbolic shift sequence 1..max_shift, with
  // the indices 4, 13, 40, ... taken twice.
  function automatic int hyp_iter_count(input int max_shift);
    int n = 0;
    int rep = 4;
    for (int s = 1; s <= max_shift; s++) begin
      n++;
      if (s == rep) begin
        n++;
        rep = 3 * rep + 1;
      end
    end
    return n;
  endfunction

  // Square of the hyperbolic CORDIC gain over the same sequence.
  function automatic real hyp_gain_sq(input int max_shift);
    real g = 1.0;
    real q = 1.0;
    int rep = 4;
    for (int s = 1; s <= max_shift; s++) begin
      q = q / 4.0;
      g = g * (1.0 - q);
      if (s == rep) begin
        g = g * (1.0 - q);
        rep = 3 * rep + 1;
      end
    end
    return g;
  endfunction

endpackage

// File: rtl/sqrt_ctrl.sv
module sqrt_ctrl
  import cordic_sqrt_pkg::*;
#(
  parameter int LOG2W = 4,
  parameter int NITER = 17,
  parameter int RW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             norm_en,
  output logic [LOG2W-1:0] norm_amt,
  output logic             init_en,
  output logic             iter_en,
  output logic [RW-1:0]    shift_amt,
  output logic             scale_en,
  output logic             write_en
);

  localparam int CW      = $clog2(NITER + LOG2W + 1);
  localparam int LATENCY = LOG2W + 1 + NITER + 2;
  localparam int LW      = $clog2(LATENCY + 2);

  sqrt_state_e state, state_d;
  logic [CW-1:0] cnt;
  logic [RW-1:0] shift_q, rep_q;
  logic          rep_done;
  logic          rdy_q, vld_q;
  logic [LW-1:0] lat_q;

  always_comb begin
    state_d  = state;
    load     = 1'b0;
    norm_en  = 1'b0;
    init_en  = 1'b0;
    norm_amt = '0;
    unique case (state)
      ST_IDLE: if (in_valid) begin
        load    = 1'b1;
        state_d = ST_NORM;
      end
      ST_NORM: if (cnt == CW'(LOG2W - 1)) begin
        init_en = 1'b1;
        state_d = ST_ITER;
      end else begin
        norm_en  = 1'b1;
        norm_amt = LOG2W'(1 << (LOG2W - 1 - int'(cnt)));
      end
      ST_ITER:  if (cnt == CW'(NITER - 1)) state_d = ST_SCALE;
      ST_SCALE: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_HOLD;
      ST_HOLD:  if (out_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign iter_en   = (state == ST_ITER);
  assign scale_en  = (state == ST_SCALE);
  assign write_en  = (state == ST_WRITE);
  assign shift_amt = shift_q;
  assign in_ready  = rdy_q;
  assign out_valid = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rdy_q    <= 1'b1;
      vld_q    <= 1'b0;
      shift_q  <= RW'(1);
      rep_q    <= RW'(4);
      rep_done <= 1'b0;
      lat_q    <= '0;
    end else begin
      state <= state_d;
      rdy_q <= (state_d == ST_IDLE);
      vld_q <= (state_d == ST_HOLD);
      if (state != state_d)
        cnt <= '0;
      else if (state == ST_NORM || state == ST_ITER)
        cnt <= cnt + 1'b1;
      if (init_en) begin
        shift_q  <= RW'(1);
        rep_q    <= RW'(4);
        rep_done <= 1'b0;
      end else if (iter_en) begin
        if (shift_q == rep_q && !rep_done) begin
          rep_done <= 1'b1;
        end else begin
          shift_q <= shift_q + 1'b1;
          if (rep_done) begin
            rep_q    <= RW'(3 * int'(rep_q) + 1);
            rep_done <= 1'b0;
          end
        end
      end
      if (load)
        lat_q <= LW'(1);
      else if (state != ST_IDLE && state != ST_HOLD)
        lat_q <= lat_q + 1'b1;
    end
  end

  // R2: an accepted sample closes the input side
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);

  // R4: the result appears a fixed number of edges after acceptance
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> lat_q == LW'(LATENCY));

  // R6: the input side reopens one cycle after the output transfer
  a_r6_reopen: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> in_ready && !out_valid);

  // R7: never idle and holding a result at once
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

endmodule

// File: rtl/sqrt_norm.sv
module sqrt_norm #(
  parameter int DW    = 16,
  parameter int LOG2W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step_en,
  input  logic [LOG2W-1:0] step_amt,
  input  logic [DW-1:0]    din,
  output logic [DW-2:0]    mant,
  output logic [LOG2W-1:0] lz_even,
  output logic             is_zero
);

  localparam int MW = DW - 1;

  logic [MW-1:0]    w_q;
  logic [LOG2W-1:0] z_q;
  logic             zero_q;
  logic [MW-1:0]    top_bits;

  // bits that would leave the field under this step's shift
  assign top_bits = w_q >> (MW - int'(step_amt));

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q    <= '0;
      z_q    <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      w_q    <= din[MW-1:0];
      z_q    <= '0;
      zero_q <= din[DW-1] || (din[MW-1:0] == '0);
    end else if (step_en && top_bits == '0) begin
      w_q <= w_q << step_amt;
      z_q <= z_q + step_amt;
    end
  end

  assign mant    = w_q;
  assign lz_even = z_q;
  assign is_zero = zero_q;

endmodule

// File: rtl/sqrt_kernel.sv
module sqrt_kernel
  import cordic_sqrt_pkg::*;
#(
  parameter int DW = 16,
  parameter int FI = 20,
  parameter int RW = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   init_en,
  input  logic                   iter_en,
  input  logic [RW-1:0]          shift_amt,
  input  logic [DW-2:0]          mant,
  output logic signed [FI+3:0]   x_out
);

  localparam int  IW     = FI + 4;
  localparam int  MW     = DW - 1;
  localparam int  MSH    = FI - (DW - 2);
  localparam real C_REAL = 0.25 / hyp_gain_sq(DW - 1);
  localparam logic signed [IW-1:0] C_FIX = IW'($rtoi(C_REAL * $itor(1 << FI) + 0.5));

  logic signed [IW-1:0] x_q, y_q, m_ext, dx, dy;

  assign m_ext = $signed({{(IW - MW){1'b0}}, mant}) <<< MSH;
  assign dx    = x_q >>> shift_amt;
  assign dy    = y_q >>> shift_amt;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (init_en) begin
      x_q <= m_ext + C_FIX;
      y_q <= m_ext - C_FIX;
    end else if (iter_en) begin
      if (!y_q[IW-1]) begin
        x_q <= x_q - dy;
        y_q <= y_q - dx;
      end else begin
        x_q <= x_q + dy;
        y_q <= y_q + dx;
      end
    end
  end

  assign x_out = x_q;

  // R8: the magnitude term stays positive through every iteration
  a_r8_x_positive: assert property (@(posedge clk) disable iff (rst)
    iter_en |-> !x_q[IW-1]);

endmodule

// File: rtl/sqrt_denorm.sv
module sqrt_denorm #(
  parameter int DW    = 16,
  parameter int FW    = 10,
  parameter int FI    = 20,
  parameter int LOG2W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scale_en,
  input  logic                 write_en,
  input  logic signed [FI+3:0] x_in,
  input  logic [LOG2W-1:0]     lz_even,
  input  logic                 is_zero,
  output logic [DW-1:0]        out_data
);

  localparam int IW   = FI + 4;
  localparam int BASE = FI - FW - (DW - 2 - FW) / 2;

  int                   rs;
  logic signed [IW-1:0] half, rounded;
  logic [DW-1:0]        scaled_q, out_q;

  always_comb begin
    rs      = BASE + int'(lz_even >> 1);
    half    = $signed({{(IW - 1){1'b0}}, 1'b1}) <<< (rs - 1);
    rounded = x_in + half;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scaled_q <= '0;
      out_q    <= '0;
    end else begin
      if (scale_en) scaled_q <= DW'(rounded >>> rs);
      if (write_en) out_q    <= is_zero ? '0 : scaled_q;
    end
  end

  assign out_data = out_q;

endmodule

// File: rtl/cordic_sqrt_iter.sv
module cordic_sqrt_iter
  import cordic_sqrt_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 10,
  parameter int FI = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  localparam int LOG2W = $clog2(DW);
  localparam int NITER = hyp_iter_count(DW - 1);
  localparam int RW    = $clog2(3 * DW);

  logic             load, norm_en, init_en, iter_en, scale_en, write_en, is_zero;
  logic [LOG2W-1:0] norm_amt, lz_even;
  logic [RW-1:0]    shift_amt;
  logic [DW-2:0]    mant;
  logic signed [FI+3:0] x_fin;

  sqrt_ctrl #(.LOG2W(LOG2W), .NITER(NITER), .RW(RW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load),
    .norm_en(norm_en), .norm_amt(norm_amt), .init_en(init_en),
    .iter_en(iter_en), .shift_amt(shift_amt), .scale_en(scale_en),
    .write_en(write_en)
  );

  sqrt_norm #(.DW(DW), .LOG2W(LOG2W)) u_norm (
    .clk(clk), .rst(rst), .load(load), .step_en(norm_en),
    .step_amt(norm_amt), .din(in_data), .mant(mant),
    .lz_even(lz_even), .is_zero(is_zero)
  );

  sqrt_kernel #(.DW(DW), .FI(FI), .RW(RW)) u_kernel (
    .clk(clk), .rst(rst), .init_en(init_en), .iter_en(iter_en),
    .shift_amt(shift_amt), .mant(mant), .x_out(x_fin)
  );

  sqrt_denorm #(.DW(DW), .FW(FW), .FI(FI), .LOG2W(LOG2W)) u_denorm (
    .clk(clk), .rst(rst), .scale_en(scale_en), .write_en(write_en),
    .x_in(x_fin), .lz_even(lz_even), .is_zero(is_zero),
    .out_data(out_data)
  );

  // R5: a stalled result is held unchanged
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: tb/cordic_sqrt_iter_bench.sv
module cordic_sqrt_iter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int FW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cordic_sqrt_iter u_cordic_sqrt_iter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real ideal_root(input int u);
    return $sqrt(real'(u) / real'(1 << FW)) * real'(1 << FW);
  endfunction

  task automatic run_one(input logic [DW-1:0] d, input int stall, input string tag);
    logic [DW-1:0] held;
    int edges = 0;
    real want, diff;
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R2", int'(in_ready), 0);
    // junk on the input side while busy (R3)
    while (!out_valid && edges < 100) begin
      in_valid = 1'($urandom_range(0, 1));
      in_data  = DW'($urandom);
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(edges == 23, "R4", edges, 23);
    check(!in_ready, "R7", int'(in_ready), 0);
    if (d[DW-1]) begin
      check(out_data == '0, "R10", int'(out_data), 0);
    end else if (d == '0) begin
      check(out_data == '0, "R9", int'(out_data), 0);
    end else begin
      want = ideal_root(int'(d));
      diff = real'(out_data) - want;
      if (diff < 0.0) diff = -diff;
      check(diff <= 1.0, tag, int'(out_data), int'(want + 0.5));
    end
    held = out_data;
    for (int k = 0; k < stall; k++) begin
      in_valid = 1'($urandom_range(0, 1));
      in_data  = DW'($urandom);
      @(posedge clk);
      @(negedge clk);
      check(out_valid && out_data == held, "R5", int'(out_data), int'(held));
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R6", int'({in_ready, out_valid}), 2);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", int'({in_ready, out_valid}), 2);

    run_one(16'h0000, 1, "R9");
    run_one(16'h0001, 0, "R8");
    run_one(16'h0002, 2, "R8");
    run_one(16'h0003, 0, "R8");
    run_one(16'h0004, 1, "R8");
    run_one(16'h0400, 0, "R8");
    run_one(16'h1000, 3, "R8");
    run_one(16'h7FFF, 2, "R8");
    run_one(16'h4000, 0, "R8");
    run_one(16'h0155, 4, "R3");
    run_one(16'h8005, 1, "R10");
    run_one(16'hFFFF, 0, "R10");
    for (int i = 0; i < 40; i++) begin
      run_one(DW'($urandom_range(0, 32767)), $urandom_range(0, 3), "R8");
    end
    for (int i = 0; i < 10; i++) begin
      run_one(DW'($urandom_range(1, 63)), $urandom_range(0, 2), "R8");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule